// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block is the acknowledge path of a virtual CPU interrupt interface. It keeps a small table of list entries (four by default). Each entry holds a 10-bit interrupt ID, an 8-bit priority, a group bit, a hardware-linked flag, a 3-bit source-CPU field and a 2-bit state. Software writes whole entries through a load port. The guest acknowledges an interrupt by sending an acknowledge request. The block answers with a 32-bit acknowledge word.

On an accepted request the block finds the pending entry with the best priority. It then either hands back that entry's ID or one of two reserved spurious IDs. On a real acknowledge, in the same clock edge, the entry becomes active and one bit of a 32-bit active-priority bitmap is set. That bitmap then blocks later acknowledges of equal or lower group priority. The state of every entry and the bitmap are visible on output pins.

The request and the response each use a valid/ready handshake. A request is taken only when the response register is empty, or when it is being emptied in that same cycle. A response stays on the pins, unchanged, until the consumer raises ready. The load port never stalls.

Top module: `vack_unit`

## Requirements
- R1: The acknowledge word has bits [31:13] at zero in every response. The ID sits in bits [9:0]. Spurious "nothing to signal" is 1023 and spurious "wrong group" is 1022.
- R2: The selected entry is the entry in state pending (code 01) with the numerically lowest priority value. When several entries share that value, the one with the lowest index wins.
- R3: On a real acknowledge, the selected entry's state changes from pending (01) to active (10) in the edge that accepts the request.
- R4: A real acknowledge sets bit pri[7:3] of the active-priority bitmap. Bits are never cleared except by reset.
- R5: If the selected entry has its hardware flag at 0, its source field appears in word bits [12:10]. If the flag is 1, those bits are zero.
- R6: The word is 1023 in any of these cases: the interface enable or the hypervisor enable is 0; no entry is pending; the best pending priority is not strictly below the priority mask; or pri[7:3] is not strictly below the index of the lowest set bitmap bit.
- R7: The word is 1022 when the selected entry is group 1 and the acknowledge-control input is 0, provided R6 does not already apply.
- R8: A spurious response (1022 or 1023) leaves every entry's state and the bitmap unchanged.
- R9: A request is accepted when ack_req_valid and ack_req_ready are both 1. ack_req_ready equals (not ack_resp_valid) or ack_resp_ready. While ack_resp_valid is 1 and ack_resp_ready is 0, the response word is held stable.
- R10: ld_ready is always 1. A load in the same cycle as an accepted request does not affect that request, because the selection uses the contents from before the edge. If the load targets the entry being acknowledged, the loaded value wins.
- R11: After reset, ack_resp_valid is 0, every entry is invalid (00) and the bitmap is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vif_en | input | 1 | Virtual interface signaling enable |
| hyp_en | input | 1 | Hypervisor enable |
| ack_ctl | input | 1 | Allows group 1 entries to be acknowledged |
| pri_mask | input | 8 | Priority mask; only values strictly below it are signaled |
| ld_valid | input | 1 | Load an entry |
| ld_ready | output | 1 | Load accepted (always 1) |
| ld_idx | input | 2 | Entry index to load |
| ld_id | input | 10 | Interrupt ID |
| ld_pri | input | 8 | Priority (lower value is more urgent) |
| ld_grp1 | input | 1 | Group 1 when set |
| ld_hw | input | 1 | Hardware-linked when set |
| ld_src | input | 3 | Source-CPU field |
| ld_state | input | 2 | 00 invalid, 01 pending, 10 active, 11 pending and active |
| ack_req_valid | input | 1 | Acknowledge request |
| ack_req_ready | output | 1 | Request can be accepted |
| ack_resp_valid | output | 1 | Acknowledge word available |
| ack_resp_ready | input | 1 | Consumer takes the word |
| ack_resp_word | output | 32 | Acknowledge word |
| act_pri_bits | output | 32 | Active-priority bitmap |
| lr_states | output | 8 | Entry i state at bits [2i+1:2i] |

## Verification
The acknowledge update and a software load can land on the list table in the same cycle. The bench provokes this by raising ld_valid in the very cycle a request is accepted. In one case the load targets a different entry, and in another it targets the entry being acknowledged. The result is judged at the ports. The response must reflect the contents from before the edge. The loaded entry must then show the loaded state, and in the first case it must be the one acknowledged next. The bitmap must still record the acknowledged priority.

// File: rtl/vack_pkg.sv
`timescale 1ns/1ps
package vack_pkg;
  localparam int ID_W    = 10;
  localparam int PRI_W   = 8;
  localparam int SRC_W   = 3;
  localparam int WORD_W  = 32;
  localparam int GRP_W   = 5;
  localparam int SRC_LSB = ID_W;
  localparam int ACT_W   = 1 << GRP_W;

  localparam logic [ID_W-1:0] SPUR_NONE = ID_W'(1023);
  localparam logic [ID_W-1:0] SPUR_GRP  = ID_W'(1022);

  typedef enum logic [1:0] {
    LR_INVALID = 2'b00,
    LR_PENDING = 2'b01,
    LR_ACTIVE  = 2'b10,
    LR_BOTH    = 2'b11
  } lr_state_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [PRI_W-1:0] pri;
    logic             grp1;
    logic             hw;
    logic [SRC_W-1:0] src;
    lr_state_e        state;
  } lr_entry_t;
endpackage

// File: rtl/vack_list.sv
`timescale 1ns/1ps
module vack_list import vack_pkg::*; #(
  parameter int N_LR = 4,
  localparam int IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  lr_entry_t        ld_entry,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output lr_entry_t        entries [N_LR]
);
  lr_entry_t lr_q [N_LR];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_LR; i++) begin
      if (!rst_n) begin
        lr_q[i] <= '0;
      end else if (ld_en && ld_idx == IDX_W'(i)) begin
        lr_q[i] <= ld_entry;
      end else if (ack_en && ack_idx == IDX_W'(i)) begin
        lr_q[i].state <= LR_ACTIVE;
      end
    end
  end

  assign entries = lr_q;

  for (genvar g = 0; g < N_LR; g++) begin : g_chk
    assert_goes_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && ack_idx == IDX_W'(g) && !(ld_en && ld_idx == IDX_W'(g)))
      |=> lr_q[g].state == LR_ACTIVE);
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_idx == IDX_W'(g)) |=> lr_q[g] == $past(ld_entry));
  end
endmodule

// File: rtl/vack_select.sv
`timescale 1ns/1ps
module vack_select import vack_pkg::*; #(
  parameter int N_LR = 4,
  localparam int IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lr_entry_t        entries [N_LR],
  output logic             found,
  output logic [IDX_W-1:0] sel_idx,
  output lr_entry_t        sel_entry
);
  logic [PRI_W-1:0] best_pri;

  always_comb begin
    found    = 1'b0;
    best_pri = '1;
    sel_idx  = '0;
    for (int i = 0; i < N_LR; i++) begin
      if (entries[i].state == LR_PENDING && (!found || entries[i].pri < best_pri)) begin
        found    = 1'b1;
        best_pri = entries[i].pri;
        sel_idx  = IDX_W'(i);
      end
    end
  end

  assign sel_entry = entries[sel_idx];

  for (genvar g = 0; g < N_LR; g++) begin : g_chk
    assert_best_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (found && entries[g].state == LR_PENDING) |->
        (sel_entry.pri < entries[g].pri ||
         (sel_entry.pri == entries[g].pri && sel_idx <= IDX_W'(g))));
  end
endmodule

// File: rtl/vack_apr.sv
`timescale 1ns/1ps
module vack_apr import vack_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [GRP_W-1:0] set_idx,
  output logic [ACT_W-1:0] bits,
  output logic             any_active,
  output logic [GRP_W-1:0] top_idx
);
  logic [ACT_W-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      bits_q <= '0;
    else if (set_en) bits_q[set_idx] <= 1'b1;
  end

  always_comb begin
    top_idx = '0;
    for (int i = ACT_W - 1; i >= 0; i--) begin
      if (bits_q[i]) top_idx = GRP_W'(i);
    end
  end

  assign any_active = |bits_q;
  assign bits       = bits_q;

  assert_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(set_idx)]);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bits_q & $past(bits_q)) == $past(bits_q));
endmodule

// File: rtl/vack_unit.sv
`timescale 1ns/1ps
module vack_unit import vack_pkg::*; #(
  parameter int N_LR = 4,
  localparam int IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vif_en,
  input  logic              hyp_en,
  input  logic              ack_ctl,
  input  logic [PRI_W-1:0]  pri_mask,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ID_W-1:0]   ld_id,
  input  logic [PRI_W-1:0]  ld_pri,
  input  logic              ld_grp1,
  input  logic              ld_hw,
  input  logic [SRC_W-1:0]  ld_src,
  input  logic [1:0]        ld_state,
  input  logic              ack_req_valid,
  output logic              ack_req_ready,
  output logic              ack_resp_valid,
  input  logic              ack_resp_ready,
  output logic [WORD_W-1:0] ack_resp_word,
  output logic [ACT_W-1:0]  act_pri_bits,
  output logic [2*N_LR-1:0] lr_states
);
  lr_entry_t        entries [N_LR];
  lr_entry_t        ld_entry;
  lr_entry_t        sel_e;
  logic             found;
  logic [IDX_W-1:0] sel_idx;
  logic             any_active;
  logic [GRP_W-1:0] top_idx;
  logic             accept;
  logic             eligible;
  logic             real_ack;
  logic [WORD_W-1:0] next_word;
  logic             resp_v_q;
  logic [WORD_W-1:0] resp_w_q;

  assign ld_entry = '{id: ld_id, pri: ld_pri, grp1: ld_grp1, hw: ld_hw,
                      src: ld_src, state: lr_state_e'(ld_state)};
  assign ld_ready = 1'b1;

  vack_list #(.N_LR(N_LR)) u_list (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_valid), .ld_idx(ld_idx), .ld_entry(ld_entry),
    .ack_en(real_ack), .ack_idx(sel_idx), .entries(entries)
  );

  vack_select #(.N_LR(N_LR)) u_sel (
    .clk(clk), .rst_n(rst_n), .entries(entries),
    .found(found), .sel_idx(sel_idx), .sel_entry(sel_e)
  );

  vack_apr u_apr (
    .clk(clk), .rst_n(rst_n),
    .set_en(real_ack), .set_idx(sel_e.pri[PRI_W-1 -: GRP_W]),
    .bits(act_pri_bits), .any_active(any_active), .top_idx(top_idx)
  );

  assign accept   = ack_req_valid && ack_req_ready;
  assign eligible = found && vif_en && hyp_en && (sel_e.pri < pri_mask) &&
                    (!any_active || sel_e.pri[PRI_W-1 -: GRP_W] < top_idx);

  always_comb begin
    next_word = '0;
    real_ack  = 1'b0;
    if (!eligible) begin
      next_word[ID_W-1:0] = SPUR_NONE;
    end else if (sel_e.grp1 && !ack_ctl) begin
      next_word[ID_W-1:0] = SPUR_GRP;
    end else begin
      real_ack = accept;
      next_word[ID_W-1:0] = sel_e.id;
      if (!sel_e.hw) next_word[SRC_LSB +: SRC_W] = sel_e.src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_v_q <= 1'b0;
      resp_w_q <= '0;
    end else if (accept) begin
      resp_v_q <= 1'b1;
      resp_w_q <= next_word;
    end else if (ack_resp_ready) begin
      resp_v_q <= 1'b0;
    end
  end

  assign ack_req_ready  = !resp_v_q || ack_resp_ready;
  assign ack_resp_valid = resp_v_q;
  assign ack_resp_word  = resp_w_q;

  always_comb begin
    for (int i = 0; i < N_LR; i++) lr_states[2*i +: 2] = entries[i].state;
  end

  assert_word_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_v_q |-> resp_w_q[WORD_W-1:SRC_LSB+SRC_W] == '0);
  assert_sel_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> sel_e.state == LR_PENDING);
  assert_spur_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !real_ack) |=> $stable(act_pri_bits));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_v_q && !ack_resp_ready) |=> (resp_v_q && $stable(resp_w_q)));
endmodule

// File: tb/vack_unit_bench.sv
`timescale 1ns/1ps
module vack_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vif_en, hyp_en, ack_ctl;
  logic [7:0] pri_mask;
  logic ld_valid, ld_ready;
  logic [1:0] ld_idx;
  logic [9:0] ld_id;
  logic [7:0] ld_pri;
  logic ld_grp1, ld_hw;
  logic [2:0] ld_src;
  logic [1:0] ld_state;
  logic ack_req_valid, ack_req_ready, ack_resp_valid, ack_resp_ready;
  logic [31:0] ack_resp_word, act_pri_bits;
  logic [7:0] lr_states;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  vack_unit u_vack_unit (
    .clk(clk), .rst_n(rst_n), .vif_en(vif_en), .hyp_en(hyp_en), .ack_ctl(ack_ctl),
    .pri_mask(pri_mask), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_idx),
    .ld_id(ld_id), .ld_pri(ld_pri), .ld_grp1(ld_grp1), .ld_hw(ld_hw), .ld_src(ld_src),
    .ld_state(ld_state), .ack_req_valid(ack_req_valid), .ack_req_ready(ack_req_ready),
    .ack_resp_valid(ack_resp_valid), .ack_resp_ready(ack_resp_ready),
    .ack_resp_word(ack_resp_word), .act_pri_bits(act_pri_bits), .lr_states(lr_states)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ack_resp_valid && ack_resp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", ack_resp_word, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(ack_resp_word == e, t, ack_resp_word, e);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; vif_en = 1; hyp_en = 1; ack_ctl = 0; pri_mask = 8'hFF;
    ld_valid = 0; ld_idx = 0; ld_id = 0; ld_pri = 0; ld_grp1 = 0; ld_hw = 0;
    ld_src = 0; ld_state = 0; ack_req_valid = 0; ack_resp_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic load(input int idx, input int id, input int pri, input bit g1,
                      input bit hw, input int src, input int st);
    @(posedge clk); #1;
    ld_valid = 1; ld_idx = 2'(idx); ld_id = 10'(id); ld_pri = 8'(pri);
    ld_grp1 = g1; ld_hw = hw; ld_src = 3'(src); ld_state = 2'(st);
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic do_ack(input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    ack_req_valid = 1;
    while (!ack_req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    ack_req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  function automatic logic [1:0] st(input int i);
    return lr_states[2*i +: 2];
  endfunction

  initial begin
    do_reset();
    // reset state
    chk(ack_resp_valid == 0, "R11 resp_valid after reset", 32'(ack_resp_valid), 0);
    chk(act_pri_bits == 0, "R11 bitmap after reset", act_pri_bits, 0);
    chk(lr_states == 0, "R11 entries invalid", 32'(lr_states), 0);
    chk(ld_ready == 1 && ack_req_ready == 1, "R10 ready after reset", 32'({ld_ready, ack_req_ready}), 3);
    do_ack(32'd1023, "R6 empty table");
    drain();

    // selection with tie and hw flag
    load(0, 40, 8'h60, 0, 0, 3, 1);
    load(1, 41, 8'h30, 0, 1, 5, 1);
    load(2, 42, 8'h30, 0, 0, 6, 1);
    load(3, 43, 8'h80, 0, 0, 1, 1);
    do_ack(32'd41, "R2 tie lowest index, R5 hw zero src");
    chk(st(1) == 2'b10, "R3 entry1 active", 32'(st(1)), 2);
    chk(act_pri_bits == 32'h40, "R4 bit 6 set", act_pri_bits, 32'h40);
    drain();
    do_ack(32'd1023, "R6 blocked by active group");
    drain();
    chk(lr_states == 8'b01_01_10_01, "R8 states unchanged", 32'(lr_states), 32'b01_01_10_01);
    chk(act_pri_bits == 32'h40, "R8 bitmap unchanged", act_pri_bits, 32'h40);

    // software source copy
    do_reset();
    load(0, 7, 8'h20, 0, 0, 2, 1);
    do_ack(32'h807, "R5 sw source bits 12:10");
    drain();
    chk(act_pri_bits == 32'h10, "R4 bit 4 set", act_pri_bits, 32'h10);

    // enables and mask
    do_reset();
    load(0, 12, 8'h50, 0, 0, 0, 1);
    vif_en = 0;
    do_ack(32'd1023, "R6 interface disabled");
    drain();
    vif_en = 1; hyp_en = 0;
    do_ack(32'd1023, "R6 hypervisor disabled");
    drain();
    hyp_en = 1; pri_mask = 8'h50;
    do_ack(32'd1023, "R6 mask not strictly above");
    drain();
    chk(st(0) == 2'b01, "R8 entry still pending", 32'(st(0)), 1);
    chk(act_pri_bits == 0, "R8 bitmap still zero", act_pri_bits, 0);
    pri_mask = 8'h51;
    do_ack(32'd12, "R6 mask strictly above");
    drain();

    // group 1 with ack control
    do_reset();
    load(0, 20, 8'h10, 1, 0, 0, 1);
    load(1, 21, 8'h18, 0, 0, 0, 1);
    do_ack(32'd1022, "R7 group1 without ack control");
    drain();
    chk(st(0) == 2'b01, "R8 group1 entry pending", 32'(st(0)), 1);
    chk(act_pri_bits == 0, "R8 bitmap zero after 1022", act_pri_bits, 0);
    ack_ctl = 1;
    do_ack(32'd20, "R7 group1 with ack control");
    drain();
    chk(act_pri_bits == 32'h4, "R4 bit 2 set", act_pri_bits, 32'h4);

    // back-pressure
    do_reset();
    load(0, 3, 8'h40, 0, 0, 0, 1);
    ack_resp_ready = 0;
    do_ack(32'd3, "R9 held response");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(ack_req_ready == 0, "R9 ready low while held", 32'(ack_req_ready), 0);
      chk(ack_resp_valid == 1 && ack_resp_word == 32'd3, "R9 word stable", ack_resp_word, 3);
    end
    @(posedge clk); #1 ack_resp_ready = 1;
    drain();

    // load and acknowledge in the same cycle, other entry
    do_reset();
    load(0, 30, 8'h40, 0, 0, 0, 1);
    load(1, 31, 8'h44, 0, 0, 0, 1);
    exp_q.push_back(32'd30); tag_q.push_back("R10 ack uses old contents");
    @(posedge clk); #1;
    ack_req_valid = 1; ld_valid = 1; ld_idx = 1; ld_id = 33; ld_pri = 8'h10;
    ld_grp1 = 0; ld_hw = 0; ld_src = 0; ld_state = 2'b01;
    @(posedge clk); #1;
    ack_req_valid = 0; ld_valid = 0;
    chk(st(0) == 2'b10 && st(1) == 2'b01, "R10 states after collision", 32'(lr_states[3:0]), 32'b0110);
    drain();
    do_ack(32'd33, "R10 new entry acknowledged");
    drain();

    // same entry: load wins
    do_reset();
    load(0, 50, 8'h40, 0, 0, 0, 1);
    exp_q.push_back(32'd50); tag_q.push_back("R10 same-entry response");
    @(posedge clk); #1;
    ack_req_valid = 1; ld_valid = 1; ld_idx = 0; ld_id = 51; ld_pri = 8'h40;
    ld_state = 2'b01;
    @(posedge clk); #1;
    ack_req_valid = 0; ld_valid = 0;
    chk(st(0) == 2'b01, "R10 load wins state", 32'(st(0)), 1);
    chk(act_pri_bits == 32'h100, "R4 bit 8 set", act_pri_bits, 32'h100);
    drain();
    do_ack(32'd1023, "R6 reloaded entry blocked by bitmap");
    drain();

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R9 all responses seen", 32'(exp_q.size()), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule